// File: doc/BRIEF.md
# Port-Style Configuration Access Unit

This block gives a host an eight-byte window through which it reaches the configuration registers of devices on a single-bus, PCI-like fabric. The first word of the window is an address latch. The host fills it with an enable flag, a bus number, a device number, a function number and a register index. The second word is a data window. Reads and writes to the data window are passed on to a downstream configuration port, provided that the latched target is enabled, sits on bus 0 and is marked present.

A host access carries a byte offset into the window (0 to 15), a length from 1 to 4 bytes and, for writes, right-justified data. Each access finishes with a one-cycle acknowledge. For reads, the acknowledge carries right-justified read data. Accesses the block cannot serve finish locally. Reads of that kind return all-ones bytes and writes of that kind change nothing. Device 0 is the host bridge and is always treated as present, whatever the present vector says.

Top module: `cfg_port_unit`

## Requirements
- R1: After reset the address latch is zero, `host_ready` is 1, and both `host_ack` and `cfg_req_valid` are 0.
- R2: Window offsets 0 to 3 select the address latch and offsets 4 to 7 select the data window. A read at offset 8 to 15 returns 0xFF in each requested byte. A write at offset 8 to 15 changes nothing.
- R3: A latch write of length 1, 2 or 4 replaces only the byte lanes `off` to `off+len-1` and keeps every other bit. A latch write of length 3 is ignored.
- R4: The latch fields are decoded as follows: device = bits 15:11, driven on `cfg_dev`; register index = bits 7:2, driven on `cfg_reg`; bus = bits 23:16. The function field in bits 10:8 has no effect on which target is served.
- R5: While latch bit 31 is 0, data-window reads return 0xFF in every requested byte and data-window writes are not forwarded.
- R6: While the bus field is nonzero, data-window reads return 0xFF in every requested byte and data-window writes are not forwarded.
- R7: A device counts as present if it is device 0, or if its bit is set in `dev_present` and its index is below NDEV. An access to a device that is not present reads 0xFF in every requested byte and drops its writes.
- R8: An access with `(off mod 4) + len > 4` is rejected. A rejected read returns 0xFF in each requested byte. A rejected write changes no state and is not forwarded.
- R9: Read data is the selected 32-bit word shifted right by `8*(off mod 4)`. Only the `len` low bytes are kept and the bytes above them read as 0.
- R10: A forwarded write drives `cfg_off = off-4`, `cfg_len = len` and `cfg_wdata` = the host data with only its low `len` bytes kept.
- R11: Only one access is handled at a time, and `host_ready` is low while an access is forwarded. `cfg_req_valid` is held, with stable fields, until `cfg_req_ready` is seen. A forwarded write is acknowledged in the cycle after its handshake. A forwarded read is acknowledged in the cycle after `cfg_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, sampled while host_ready is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 4 | Byte offset into the window |
| host_len | input | 3 | Access length in bytes, 1 to 4 |
| host_wdata | input | 32 | Right-justified write data |
| host_ready | output | 1 | Unit idle, a request can be accepted |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Right-justified read data, valid with host_ack |
| dev_present | input | NDEV | Present flag for each device; bit 0 is overridden to 1 |
| cfg_req_valid | output | 1 | Downstream request valid |
| cfg_req_ready | input | 1 | Downstream request accepted |
| cfg_we | output | 1 | Downstream write flag |
| cfg_dev | output | 5 | Target device index |
| cfg_reg | output | 6 | Target register index |
| cfg_off | output | 2 | Byte offset within the register word |
| cfg_len | output | 3 | Byte count |
| cfg_wdata | output | 32 | Right-justified write data |
| cfg_rsp_valid | input | 1 | Read response valid |
| cfg_rsp_data | input | 32 | Full 32-bit register value |

## Verification
The assertions assume three things about the host. It requests only while `host_ready` is high. Its length is always between 1 and 4. It waits for `host_ack` before issuing another access. The assertions also assume that the downstream side returns exactly one response per accepted read. The stimulus holds to these assumptions: every access goes through a single task that waits for ready, pulses the request for one cycle and then waits for the acknowledge. The lengths in the sweeps run over 1 to 4 only, and the device model answers each accepted read once, one cycle later, while its ready line follows a stall pattern.

// File: rtl/cfg_port_unit.sv
module cfg_port_unit #(
  parameter int NDEV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [3:0]      host_off,
  input  logic [2:0]      host_len,
  input  logic [31:0]     host_wdata,
  output logic            host_ready,
  output logic            host_ack,
  output logic [31:0]     host_rdata,
  input  logic [NDEV-1:0] dev_present,
  output logic            cfg_req_valid,
  input  logic            cfg_req_ready,
  output logic            cfg_we,
  output logic [4:0]      cfg_dev,
  output logic [5:0]      cfg_reg,
  output logic [1:0]      cfg_off,
  output logic [2:0]      cfg_len,
  output logic [31:0]     cfg_wdata,
  input  logic            cfg_rsp_valid,
  input  logic [31:0]     cfg_rsp_data
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} st_t;

  function automatic logic [31:0] msk(input logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd3:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] v, input logic [1:0] ln,
                                       input logic [2:0] n);
    return (v >> {ln, 3'b000}) & msk(n);
  endfunction

  st_t         st;
  logic [31:0] addr_q;
  logic        we_q;
  logic [1:0]  lane_q;
  logic [2:0]  len_q;
  logic [31:0] wd_q;

  logic [31:0] pres_all;
  logic [1:0]  lane;
  logic [3:0]  span;
  logic        fits, in_latch, in_data, hit, accept, fwd, lat_wr;
  logic [31:0] lat_mask, local_rd;

  assign pres_all = 32'(dev_present) | 32'd1;
  assign lane     = host_off[1:0];
  assign span     = {2'b00, lane} + {1'b0, host_len};
  assign fits     = span <= 4'd4;
  assign in_latch = host_off[3:2] == 2'b00;
  assign in_data  = host_off[3:2] == 2'b01;
  assign hit      = addr_q[31] && addr_q[23:16] == 8'd0 && pres_all[addr_q[15:11]];
  assign accept   = host_req && st == ST_IDLE;
  assign fwd      = accept && in_data && fits && hit;
  assign lat_wr   = accept && host_we && in_latch && fits && host_len != 3'd3;
  assign lat_mask = msk(host_len) << {lane, 3'b000};
  assign local_rd = (in_latch && fits) ? pick(addr_q, lane, host_len) : msk(host_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      addr_q     <= '0;
      we_q       <= 1'b0;
      lane_q     <= '0;
      len_q      <= '0;
      wd_q       <= '0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          we_q   <= host_we;
          lane_q <= lane;
          len_q  <= host_len;
          wd_q   <= host_wdata & msk(host_len);
          if (fwd) st <= ST_REQ;
          else begin
            host_ack   <= 1'b1;
            host_rdata <= host_we ? 32'd0 : local_rd;
          end
          if (lat_wr)
            addr_q <= (addr_q & ~lat_mask) | ((host_wdata & msk(host_len)) << {lane, 3'b000});
        end
        ST_REQ: if (cfg_req_ready) begin
          if (we_q) begin
            host_ack   <= 1'b1;
            host_rdata <= 32'd0;
            st         <= ST_IDLE;
          end else st <= ST_RSP;
        end
        ST_RSP: if (cfg_rsp_valid) begin
          host_ack   <= 1'b1;
          host_rdata <= pick(cfg_rsp_data, lane_q, len_q);
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign host_ready    = st == ST_IDLE;
  assign cfg_req_valid = st == ST_REQ;
  assign cfg_we        = we_q;
  assign cfg_dev       = addr_q[15:11];
  assign cfg_reg       = addr_q[7:2];
  assign cfg_off       = lane_q;
  assign cfg_len       = len_q;
  assign cfg_wdata     = wd_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_dev) && $stable(cfg_wdata)
      && $stable(cfg_off) && $stable(cfg_len));

  // R11
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> host_ready && !cfg_req_valid);

  // R5 R6 R7
  fwd_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> addr_q[31] && addr_q[23:16] == 8'd0 && pres_all[cfg_dev]);

  // R8
  fwd_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> ({2'b00, cfg_off} + {1'b0, cfg_len}) <= 4'd4 && cfg_len != 3'd0);

  // R3
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && host_ready && host_we && host_off[3:2] == 2'b00) |=> $stable(addr_q));

  // R11
  host_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_ready |-> host_len >= 3'd1 && host_len <= 3'd4);

endmodule

// File: tb/cfg_port_unit_tb.sv
module cfg_port_unit_tb_top;
  localparam int NDEV = 8;
  localparam logic [7:0] PRES = 8'b1010_0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [3:0] host_off = '0;
  logic [2:0] host_len = 3'd1;
  logic [31:0] host_wdata = '0;
  logic host_ready, host_ack;
  logic [31:0] host_rdata;
  logic cfg_req_valid, cfg_we;
  logic cfg_req_ready;
  logic [4:0] cfg_dev;
  logic [5:0] cfg_reg;
  logic [1:0] cfg_off;
  logic [2:0] cfg_len;
  logic [31:0] cfg_wdata;
  logic cfg_rsp_valid;
  logic [31:0] cfg_rsp_data;

  always #5 clk = ~clk;

  cfg_port_unit #(.NDEV(NDEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we), .host_off(host_off),
    .host_len(host_len), .host_wdata(host_wdata), .host_ready(host_ready), .host_ack(host_ack),
    .host_rdata(host_rdata), .dev_present(PRES), .cfg_req_valid(cfg_req_valid),
    .cfg_req_ready(cfg_req_ready), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_reg(cfg_reg),
    .cfg_off(cfg_off), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data));

  logic [31:0] dmem [0:7][0:63];
  logic [31:0] exp_mem [0:7][0:63];
  logic [2:0] stall;
  int wr_cnt;
  int nchk = 0, nerr = 0;
  logic done = 1'b0;
  logic [31:0] addr_m = '0;

  function automatic logic [31:0] seed(int d, int r);
    return 32'hC0DE_0000 ^ (d << 20) ^ (r * 32'h0001_0203);
  endfunction

  function automatic logic [31:0] msk(int n);
    return (n >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 32'd1);
  endfunction

  function automatic logic [31:0] ext(logic [31:0] v, int ln, int n);
    return (v >> (8 * ln)) & msk(n);
  endfunction

  function automatic bit present(int d);
    return d == 0 || (d < 8 && PRES[d]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 8; d++)
        for (int r = 0; r < 64; r++) dmem[d][r] <= seed(d, r);
      stall <= 3'b001;
      cfg_req_ready <= 1'b0;
      cfg_rsp_valid <= 1'b0;
      cfg_rsp_data <= '0;
      wr_cnt <= 0;
    end else begin
      stall <= {stall[1:0], stall[2] ^ stall[1]};
      cfg_req_ready <= stall[0] | stall[2];
      cfg_rsp_valid <= 1'b0;
      if (cfg_req_valid && cfg_req_ready) begin
        if (cfg_we) begin
          dmem[cfg_dev[2:0]][cfg_reg] <= (dmem[cfg_dev[2:0]][cfg_reg] & ~(msk(int'(cfg_len)) << (8 * cfg_off)))
                                        | ((cfg_wdata << (8 * cfg_off)) & (msk(int'(cfg_len)) << (8 * cfg_off)));
          wr_cnt <= wr_cnt + 1;
        end else begin
          cfg_rsp_valid <= 1'b1;
          cfg_rsp_data <= dmem[cfg_dev[2:0]][cfg_reg];
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input int off, input int len, input logic [31:0] wd,
                     output logic [31:0] rd);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = we; host_off = 4'(off); host_len = 3'(len); host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_ack) @(negedge clk);
    rd = host_rdata;
  endtask

  task automatic model_latch_wr(int off, int len, logic [31:0] wd);
    logic [31:0] m;
    if (off < 4 && off + len <= 4 && len != 3) begin
      m = msk(len) << (8 * off);
      addr_m = (addr_m & ~m) | (((wd & msk(len)) << (8 * off)) & m);
    end
  endtask

  task automatic setaddr(int en, int bus, int dev, int fn, int rg);
    logic [31:0] v, rd;
    v = (32'(en) << 31) | (32'(bus & 255) << 16) | (32'(dev & 31) << 11) | (32'(fn & 7) << 8) | (32'(rg & 63) << 2);
    acc(1'b1, 0, 4, v, rd);
    addr_m = v;
  endtask

  function automatic logic [31:0] tgt_val();
    int d;
    d = int'(addr_m[15:11]);
    if (addr_m[31] && addr_m[23:16] == 8'd0 && present(d)) return exp_mem[d][int'(addr_m[7:2])];
    return 32'hFFFF_FFFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R11 watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, wd, e;
    int w0;
    for (int d = 0; d < 8; d++)
      for (int r = 0; r < 64; r++) exp_mem[d][r] = seed(d, r);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 32'(host_ready), 32'd1);
    chk("R1 ack", 32'(host_ack), 32'd0);
    chk("R1 req_valid", 32'(cfg_req_valid), 32'd0);
    acc(1'b0, 0, 4, 0, rd);
    chk("R1 latch zero", rd, 32'd0);

    // R3 R8: latch merge sweep
    for (int off = 0; off < 4; off++)
      for (int len = 1; len <= 4; len++) begin
        wd = 32'h9E37_79B9 * 32'(off * 5 + len);
        acc(1'b1, off, len, wd, rd);
        model_latch_wr(off, len, wd);
        acc(1'b0, 0, 4, 0, rd);
        chk($sformatf("R3 latch merge off=%0d len=%0d", off, len), rd, addr_m);
      end

    // R9 R8: latch read lanes
    for (int off = 0; off < 4; off++)
      for (int len = 1; len <= 4; len++) begin
        acc(1'b0, off, len, 0, rd);
        e = (off + len <= 4) ? ext(addr_m, off, len) : msk(len);
        chk($sformatf("R9 latch read off=%0d len=%0d", off, len), rd, e);
      end

    // R2: out-of-window offsets
    for (int off = 8; off < 16; off++) begin
      acc(1'b0, off, 1, 0, rd);
      chk($sformatf("R2 hole read off=%0d", off), rd, 32'hFF);
      acc(1'b1, off, 1, 32'h5A, rd);
      acc(1'b0, 0, 4, 0, rd);
      chk($sformatf("R2 hole write off=%0d", off), rd, addr_m);
    end

    // R4 R7 R9: data-window read sweep
    for (int d = 0; d < 8; d++) begin
      setaddr(1, 0, d, d * 3, 5 + d);
      for (int ln = 0; ln < 4; ln++)
        for (int len = 1; len <= 4; len++) begin
          acc(1'b0, 4 + ln, len, 0, rd);
          e = (ln + len <= 4) ? ext(tgt_val(), ln, len) : msk(len);
          chk($sformatf("R7 R9 data read dev=%0d lane=%0d len=%0d", d, ln, len), rd, e);
        end
    end
    // R4: device beyond NDEV
    setaddr(1, 0, 20, 0, 1);
    acc(1'b0, 4, 4, 0, rd);
    chk("R4 dev20 absent", rd, 32'hFFFF_FFFF);

    // R10 R8 R7: data-window writes
    for (int d = 0; d < 3; d++)
      for (int ln = 0; ln < 4; ln++)
        for (int len = 1; len <= 4; len++) begin
          setaddr(1, 0, d, 7, 9 + ln);
          wd = 32'hA5C3_1E0F ^ 32'(d * 256 + ln * 16 + len);
          w0 = wr_cnt;
          acc(1'b1, 4 + ln, len, wd, rd);
          if (present(d) && ln + len <= 4) begin
            e = msk(len) << (8 * ln);
            exp_mem[d][9 + ln] = (exp_mem[d][9 + ln] & ~e) | ((wd << (8 * ln)) & e);
            chk($sformatf("R10 fwd count dev=%0d", d), 32'(wr_cnt - w0), 32'd1);
          end else
            chk($sformatf("R8 R7 dropped dev=%0d lane=%0d len=%0d", d, ln, len), 32'(wr_cnt - w0), 32'd0);
          acc(1'b0, 4, 4, 0, rd);
          chk($sformatf("R10 readback dev=%0d lane=%0d len=%0d", d, ln, len), rd, tgt_val());
        end

    // R5: enable clear
    setaddr(0, 0, 1, 0, 3);
    acc(1'b0, 4, 4, 0, rd);
    chk("R5 disabled read", rd, 32'hFFFF_FFFF);
    acc(1'b0, 5, 2, 0, rd);
    chk("R5 disabled read len2", rd, 32'h0000_FFFF);
    w0 = wr_cnt;
    acc(1'b1, 4, 4, 32'h1234_5678, rd);
    chk("R5 disabled write", 32'(wr_cnt - w0), 32'd0);
    setaddr(1, 0, 1, 0, 3);
    acc(1'b0, 4, 4, 0, rd);
    chk("R5 value kept", rd, exp_mem[1][3]);

    // R6: nonzero bus
    setaddr(1, 2, 1, 0, 3);
    acc(1'b0, 4, 4, 0, rd);
    chk("R6 bus2 read", rd, 32'hFFFF_FFFF);
    w0 = wr_cnt;
    acc(1'b1, 4, 4, 32'h1234_5678, rd);
    chk("R6 bus2 write", 32'(wr_cnt - w0), 32'd0);
    setaddr(1, 0, 1, 0, 3);
    acc(1'b0, 4, 4, 0, rd);
    chk("R6 value kept", rd, exp_mem[1][3]);

    // R11: busy during forwarded read
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_off = 4'd4; host_len = 3'd4;
    @(negedge clk);
    host_req = 1'b0;
    chk("R11 busy ready", 32'(host_ready), 32'd0);
    chk("R11 busy ack", 32'(host_ack), 32'd0);
    while (!host_ack) @(negedge clk);
    chk("R11 read data", host_rdata, exp_mem[1][3]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule